// File: doc/BRIEF.md
# Row-Column Addressed Single-Bit Static RAM

This block is a synchronous static memory of 1024 one-bit cells, laid out as a square array of 32 rows and 32 columns. The 10-bit address is split into two fields. The low five bits pick a row and the high five bits pick a column. Each field drives its own one-hot decoder. The cell at the crossing of the selected row and the selected column is the only one that takes part in an access. Both select vectors are brought out as ports, so the decode can be observed from outside.

A client drives an active-low chip select and a write-low/read-high direction bit, together with one data-in bit. On a rising clock edge with the chip selected, a write stores the data bit and echoes it on the data output. A read presents the addressed cell on the data output one cycle after the address is applied. While the chip is deselected, the data output is held low and its valid flag is cleared, in place of a tri-stated pin.

After reset, a sweep clears every cell to zero, one cell per clock. A busy output stays high for the whole sweep, and all client accesses are ignored while it is high.

Top module: `rowcol_sram`

## Requirements
- R1: The array holds 1024 independent bits. Address bits [4:0] give the row and bits [9:5] give the column. Writing one address never changes the value read back from any other address.
- R2: While not busy with cs_n low, row_sel equals 1 shifted left by addr[4:0], and col_sel equals 1 shifted left by addr[9:5].
- R3: While not busy with cs_n high, row_sel and col_sel are all zero and no cell changes. After that edge, dout is 0 and dout_vld is 0.
- R4: With cs_n low and wr_n low at a rising edge (not busy), din is stored in the addressed cell.
- R5: In the cycle after such a write edge, dout equals the written bit and dout_vld is 1.
- R6: With cs_n low and wr_n high at a rising edge (not busy), the next cycle shows the addressed cell on dout with dout_vld at 1. No cell changes.
- R7: After rst_n is released, busy stays high for exactly 1024 rising edges, then falls and stays low until the next reset.
- R8: Once the sweep completes, every cell reads 0.
- R9: While busy, client inputs have no effect on any cell, and dout and dout_vld are 0. row_sel and col_sel each have exactly one bit set.
- R10: A rising edge with rst_n low sets busy to 1 and sets dout and dout_vld to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the clearing sweep |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Direction: 0 writes, 1 reads |
| addr | input | 10 | Cell address: [4:0] row, [9:5] column |
| din | input | 1 | Bit to store on a write |
| dout | output | 1 | Registered read data, or the echoed write data |
| dout_vld | output | 1 | High when dout carries an access result |
| busy | output | 1 | High while the post-reset sweep runs |
| row_sel | output | 32 | One-hot row select |
| col_sel | output | 32 | One-hot column select |

## Verification
The hardest case to reach is a stale bit left over from before a reset. Such a bit only shows up if a cell is written, the block is reset in the middle of a run, and that cell is read after the second sweep. The stimulus does exactly this: it fills the array with ones from a mixed random run, asserts reset mid-stream, and reads every address afterwards. It also issues random writes while busy is high, to show that the sweep owns the array during that time. Corner addresses in both fields (row 0 and 31, column 0 and 31) get walking writes, each followed by reads of neighbouring cells.

// File: rtl/rowcol_sram_pkg.sv
// Package: shared geometry constants for the row-column single-bit RAM.
// Assumes a square-or-rectangular array whose sides are powers of two.
package rowcol_sram_pkg;
    localparam int ROW_BITS_DEF = 5;
    localparam int COL_BITS_DEF = 5;
endpackage

// File: rtl/rowcol_sram_decoder.sv
// Module: binary-to-one-hot decoder with an enable.
// Assumes N equals 2**W; output is all zero while en is low.
module rowcol_sram_decoder #(
    parameter int W = 5,
    localparam int N = 1 << W
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] sel
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // One select line per decoded value.
        assign sel[i] = en && (idx == W'(i));
    end
endmodule

// File: rtl/rowcol_sram_sweep.sv
// Module: post-reset clearing sequencer; walks every cell address once.
// Assumes the array consumes one cell per cycle while busy is high.
module rowcol_sram_sweep #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          busy,
    output logic [AW-1:0] sweep_addr
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    // Step the address through the whole array, then drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b1;
            sweep_addr <= '0;
        end else if (busy) begin
            sweep_addr <= sweep_addr + 1'b1;
            if (sweep_addr == LAST) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/rowcol_sram_array.sv
// Module: cell storage addressed by crossing one-hot row and column lines.
// Assumes at most one row line and one column line are high; no reset on cells.
module rowcol_sram_array #(
    parameter int ROWS = 32,
    parameter int COLS = 32
) (
    input  logic            clk,
    input  logic [ROWS-1:0] row_sel,
    input  logic [COLS-1:0] col_sel,
    input  logic            wr_en,
    input  logic            wr_bit,
    output logic            rd_bit
);
    logic [COLS-1:0] row_gated [ROWS];
    logic [COLS-1:0] picked_row;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] cells_q;
        // Update only the selected column bit of the selected row.
        always_ff @(posedge clk) begin
            if (wr_en && row_sel[r])
                cells_q <= (cells_q & ~col_sel) | (col_sel & {COLS{wr_bit}});
        end
        assign row_gated[r] = row_sel[r] ? cells_q : '0;
    end

    // OR the gated rows together into the one active row.
    always_comb begin
        picked_row = '0;
        for (int r = 0; r < ROWS; r++) picked_row = picked_row | row_gated[r];
    end

    assign rd_bit = |(picked_row & col_sel);
endmodule

// File: rtl/rowcol_sram.sv
// Module: 1024x1 synchronous static RAM with row/column decode and clear sweep.
// Assumes synchronous active-low reset; accesses are ignored while busy.
module rowcol_sram
    import rowcol_sram_pkg::*;
#(
    parameter int ROW_BITS = ROW_BITS_DEF,
    parameter int COL_BITS = COL_BITS_DEF,
    localparam int AW   = ROW_BITS + COL_BITS,
    localparam int ROWS = 1 << ROW_BITS,
    localparam int COLS = 1 << COL_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    input  logic            din,
    output logic            dout,
    output logic            dout_vld,
    output logic            busy,
    output logic [ROWS-1:0] row_sel,
    output logic [COLS-1:0] col_sel
);
    logic [AW-1:0] sweep_addr;
    logic [AW-1:0] eff_addr;
    logic          dec_en;
    logic          arr_we;
    logic          arr_wbit;
    logic          arr_rbit;

    rowcol_sram_sweep #(.AW(AW)) sweep_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .sweep_addr(sweep_addr)
    );

    // Route the sweep or the client onto the decoders and write port.
    always_comb begin
        eff_addr = busy ? sweep_addr : addr;
        dec_en   = busy || !cs_n;
        arr_we   = busy || (!cs_n && !wr_n);
        arr_wbit = busy ? 1'b0 : din;
    end

    rowcol_sram_decoder #(.W(ROW_BITS)) row_dec_i (
        .en(dec_en), .idx(eff_addr[ROW_BITS-1:0]), .sel(row_sel)
    );

    rowcol_sram_decoder #(.W(COL_BITS)) col_dec_i (
        .en(dec_en), .idx(eff_addr[AW-1:ROW_BITS]), .sel(col_sel)
    );

    rowcol_sram_array #(.ROWS(ROWS), .COLS(COLS)) array_i (
        .clk(clk), .row_sel(row_sel), .col_sel(col_sel),
        .wr_en(arr_we), .wr_bit(arr_wbit), .rd_bit(arr_rbit)
    );

    // Register the access result: echo on write, cell on read, low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
        end else if (busy || cs_n) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
        end else begin
            dout     <= wr_n ? arr_rbit : din;
            dout_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/rowcol_sram_chk.sv
// Module: protocol checker for rowcol_sram, attached by bind.
// Assumes the default 10-bit address split; observes ports only.
module rowcol_sram_chk #(
    parameter int ROWS = 32,
    parameter int COLS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            wr_n,
    input logic            din,
    input logic            dout,
    input logic            dout_vld,
    input logic            busy,
    input logic [ROWS-1:0] row_sel,
    input logic [COLS-1:0] col_sel
);
    assert_select_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !busy) |-> ($countones(row_sel) == 1 && $countones(col_sel) == 1));

    assert_idle_no_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !busy) |-> (row_sel == '0 && col_sel == '0));

    assert_idle_output_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !busy) |=> (!dout && !dout_vld));

    assert_write_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !busy) |=> (dout_vld && dout == $past(din)));

    assert_read_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_n && !busy) |=> dout_vld);

    assert_busy_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!dout && !dout_vld));

    assert_busy_sweep_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(row_sel) == 1 && $countones(col_sel) == 1));
endmodule

bind rowcol_sram rowcol_sram_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .dout(dout), .dout_vld(dout_vld), .busy(busy),
    .row_sel(row_sel), .col_sel(col_sel)
);

// File: tb/rowcol_sram_tb_top.sv
// Bench: behavioural reference model compared against the RAM every cycle.
module rowcol_sram_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [9:0]  addr = '0;
    logic        din = 1'b0;
    logic        dout, dout_vld, busy;
    logic [31:0] row_sel, col_sel;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    // Reference state.
    bit ref_mem [1024];
    bit exp_busy = 1'b1;
    bit exp_dout = 1'b0;
    bit exp_vld = 1'b0;
    int sweep_cnt = 0;
    int busy_edges = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rowcol_sram dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .din(din), .dout(dout), .dout_vld(dout_vld), .busy(busy),
        .row_sel(row_sel), .col_sel(col_sel)
    );

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        cyc++;
        if (!rst_n) begin
            exp_busy = 1'b1; sweep_cnt = 0; busy_edges = 0;
            exp_dout = 1'b0; exp_vld = 1'b0;
        end else if (exp_busy) begin
            ref_mem[sweep_cnt] = 1'b0;
            sweep_cnt++; busy_edges++;
            if (sweep_cnt == 1024) exp_busy = 1'b0;
            exp_dout = 1'b0; exp_vld = 1'b0;
        end else if (cs_n) begin
            exp_dout = 1'b0; exp_vld = 1'b0;
        end else if (!wr_n) begin
            ref_mem[addr] = din; exp_dout = din; exp_vld = 1'b1;
        end else begin
            exp_dout = ref_mem[addr]; exp_vld = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output at the falling edge, before new inputs.
    task automatic compare_now();
        string rq;
        logic [31:0] er, ec;
        rq = !rst_n ? "R10" : (exp_busy ? "R9" : (cs_n ? "R3" : (wr_n ? "R6" : "R5")));
        check(busy == exp_busy, exp_busy ? "R7" : "R7", "busy", busy, exp_busy);
        check(dout == exp_dout, rq, "dout", dout, exp_dout);
        check(dout_vld == exp_vld, rq, "dout_vld", dout_vld, exp_vld);
        if (rst_n && exp_busy) begin
            check($countones(row_sel) == 1, "R9", "row_sel count", $countones(row_sel), 1);
            check($countones(col_sel) == 1, "R9", "col_sel count", $countones(col_sel), 1);
        end else if (rst_n) begin
            er = cs_n ? 32'h0 : (32'h1 << addr[4:0]);
            ec = cs_n ? 32'h0 : (32'h1 << addr[9:5]);
            check(row_sel == er, cs_n ? "R3" : "R2", "row_sel", row_sel, er);
            check(col_sel == ec, cs_n ? "R3" : "R2", "col_sel", col_sel, ec);
        end
    endtask

    // One clock of stimulus: check the last edge, then drive the next inputs.
    task automatic step(input bit c, input bit w, input int a, input bit d);
        @(negedge clk);
        if (started) compare_now();
        cs_n = c; wr_n = w; addr = 10'(a); din = d;
    endtask

    task automatic wait_sweep();
        while (exp_busy || busy) step(($urandom % 2) == 1, 1'b0, int'($urandom % 1024), 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 1024; i++) ref_mem[i] = 1'b1;
        // R10: held reset.
        repeat (3) step(1'b0, 1'b0, 5, 1'b1);
        @(negedge clk); compare_now();
        rst_n = 1'b1;
        // R9: random writes during the sweep must be ignored.
        wait_sweep();
        // R7: exactly 1024 busy edges.
        check(busy_edges == 1024, "R7", "busy length", busy_edges, 1024);
        // R8: every cell reads 0.
        for (int a = 0; a < 1024; a++) step(1'b0, 1'b1, a, 1'b0);
        // R1/R4: walking ones at corner addresses, neighbours read back.
        foreach (ref_mem[k]) begin end
        for (int i = 0; i < 6; i++) begin
            int a;
            a = (i == 0) ? 0 : (i == 1) ? 31 : (i == 2) ? 32 : (i == 3) ? 992 : (i == 4) ? 1023 : 545;
            step(1'b0, 1'b0, a, 1'b1);
            step(1'b0, 1'b1, a, 1'b0);
            step(1'b0, 1'b1, (a + 1) % 1024, 1'b0);
            step(1'b0, 1'b1, (a + 32) % 1024, 1'b0);
            step(1'b0, 1'b1, (a + 1023) % 1024, 1'b0);
        end
        // R3: deselected writes leave cells unchanged.
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, i * 25, ~ref_mem[i * 25]);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, i * 25, 1'b0);
        // R4/R5/R6: random mixed traffic.
        for (int i = 0; i < 4000; i++)
            step(($urandom % 8) == 0, ($urandom % 2) == 1, int'($urandom % 1024), ($urandom % 4) != 0);
        // R1: fill with ones, then reset mid-run; R8 after second sweep.
        for (int a = 0; a < 1024; a++) step(1'b0, 1'b0, a, 1'b1);
        @(negedge clk); compare_now();
        rst_n = 1'b0;
        repeat (2) step(1'b0, 1'b0, 7, 1'b1);
        @(negedge clk); compare_now();
        rst_n = 1'b1;
        wait_sweep();
        check(busy_edges == 1024, "R7", "busy length after re-reset", busy_edges, 1024);
        for (int a = 0; a < 1024; a++) step(1'b0, 1'b1, a, 1'b1);
        repeat (4) step(1'b1, 1'b1, 0, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule